// File: doc/BRIEF.md
# TMDS Lane Serializer

This block turns a stream of 10-bit encoded symbols, one per pixel clock, into the bit pairs that drive one serial lane of a TMDS link. A second clock runs at five times the pixel rate. On each of its cycles the block emits two bits, one for the rising edge and one for the falling edge. An external double-data-rate output register and differential buffer outside this block put them on the wire. Ten bits therefore leave in five fast cycles, which matches one pixel period exactly.

Both clocks come from one phase-locked source. The block registers the symbol in the pixel domain and toggles a flag on every pixel edge. It sees that toggle in the fast domain through two flops. A 0-to-4 beat counter resynchronises on each detected pixel edge and also runs on by itself between edges, and it loads the shift register on every wrap. A parameter turns the block into the clock lane. In that mode the input is ignored and a constant half-low/half-high word is sent every pixel period, so each symbol produces one clock period. One link uses three data instances and one clock instance. The reset is the inverse of the clock source's lock indication.

Top module: `tmds_lane_serializer`

## Requirements
- R1: Every pixel period, exactly one 10-bit input word is serialized over five consecutive fast-clock cycles, and back-to-back words follow with no gap and no repeated beat.
- R2: Bits leave least-significant first: in beat k (k = 0..4) of a word, `ser_rise` carries word bit 2k and `ser_fall` carries word bit 2k+1.
- R3: The word on `word_in` at a pixel-clock rising edge appears as beat 0 on the outputs right after the second fast-clock rising edge following that pixel edge, and the beat counter restarts at zero on that load.
- R4: While `rst` is high (asynchronous, active high), `ser_rise` and `ser_fall` are low, and they go low at once when reset is asserted in the middle of a word.
- R5: Words on `word_in` while reset is asserted are never serialized. After reset releases, the outputs of a data lane stay low until the first word captured after release reaches them, with the latency of R3.
- R6: With the clock-lane setting, the lane sends the constant word 10'b1111100000 every pixel period (beats 0 and 1 low on both outputs, beat 2 low then high, beats 3 and 4 high on both), whatever is on `word_in`.
- R7: The beat index stays within 0..4 and advances by one on every fast cycle without a load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| pix_clk | input | 1 | Pixel clock, one symbol per rising edge |
| fast_clk | input | 1 | Serial clock at five times the pixel rate, phase aligned to `pix_clk` |
| rst | input | 1 | Asynchronous active-high reset, held while the clock source is unlocked |
| word_in | input | SYM_W (10) | Encoded symbol for this lane, sampled on `pix_clk` |
| ser_rise | output | 1 | Bit for the rising edge of the current fast cycle |
| ser_fall | output | 1 | Bit for the falling edge of the current fast cycle |

## Verification
The bench rebuilds each word from five bit pairs, starting two fast edges after the pixel edge that captured it. A swapped rise/fall pair, a reversed bit order or a load that is one beat early or late scrambles the rebuilt words, so it does not hold back a mismatch. Single-bit words at both ends, alternating patterns and all-ones next to all-zeros expose a shift that drops, repeats or mirrors bits. Reset is asserted while the data lane is driving ones, and the outputs must drop at once. After each release, a word held during reset must not leak out before the first real word. A clock lane fed with random data must still produce the fixed half-low/half-high pattern.

// File: rtl/tmds_ser_pkg.sv
`timescale 1ns/1ps
package tmds_ser_pkg;

   // Bits sent per fast-clock cycle by a double-data-rate output
   localparam int unsigned LANE_BITS = 2;
   // Widest symbol the pattern helper supports
   localparam int unsigned MAX_SYM_W = 32;

   typedef enum logic {
      LANE_DATA  = 1'b0,
      LANE_CLOCK = 1'b1
   } lane_kind_e;

   // Clock-lane symbol: lower half zeros, upper half ones
   function automatic logic [MAX_SYM_W-1:0] clock_word(int unsigned w);
      logic [MAX_SYM_W-1:0] r;
      r = '0;
      for (int i = 0; i < MAX_SYM_W; i++) begin
         if ((i >= int'(w / 2)) && (i < int'(w))) r[i] = 1'b1;
      end
      return r;
   endfunction

endpackage

// File: rtl/tser_word_hold.sv
`timescale 1ns/1ps
module tser_word_hold
   import tmds_ser_pkg::*;
#(
   parameter int unsigned SYM_W = 10,
   parameter lane_kind_e  KIND  = LANE_DATA,
   parameter logic [SYM_W-1:0] FIXED_WORD = '0
) (
   input  logic             pix_clk,
   input  logic             rst,
   input  logic [SYM_W-1:0] word_in,
   output logic [SYM_W-1:0] hold_word,
   output logic             pix_tog
);

   // Toggles on every pixel edge so the fast domain can find the edge
   always_ff @(posedge pix_clk or posedge rst) begin
      if (rst) pix_tog <= 1'b0;
      else     pix_tog <= ~pix_tog;
   end

   generate
      if (KIND == LANE_DATA) begin : g_data
         logic [SYM_W-1:0] word_q;
         always_ff @(posedge pix_clk or posedge rst) begin
            if (rst) word_q <= '0;
            else     word_q <= word_in;
         end
         assign hold_word = word_q;
      end else begin : g_clock
         logic unused_word;
         assign unused_word = ^word_in;
         assign hold_word   = FIXED_WORD;
      end
   endgenerate

endmodule

// File: rtl/tser_beat_sync.sv
`timescale 1ns/1ps
module tser_beat_sync #(
   parameter int unsigned BEATS  = 5,
   parameter int unsigned BEAT_W = 3
) (
   input  logic              fast_clk,
   input  logic              rst,
   input  logic              pix_tog,
   output logic              load,
   output logic [BEAT_W-1:0] beat
);

   logic              tog_s_q;
   logic              tog_p_q;
   logic              edge_seen;
   logic              wrap;
   logic [BEAT_W-1:0] beat_q;

   // Pixel edge is seen one fast cycle after the sampled toggle changes
   assign edge_seen = tog_s_q ^ tog_p_q;
   assign wrap      = (beat_q == BEAT_W'(BEATS - 1));
   // Flywheel wrap keeps loading if an edge is late; edge realigns phase
   assign load      = edge_seen | wrap;
   assign beat      = beat_q;

   always_ff @(posedge fast_clk or posedge rst) begin
      if (rst) begin
         tog_s_q <= 1'b0;
         tog_p_q <= 1'b0;
         beat_q  <= '0;
      end else begin
         tog_s_q <= pix_tog;
         tog_p_q <= tog_s_q;
         beat_q  <= load ? '0 : beat_q + 1'b1;
      end
   end

endmodule

// File: rtl/tser_shifter.sv
`timescale 1ns/1ps
module tser_shifter
   import tmds_ser_pkg::*;
#(
   parameter int unsigned SYM_W = 10
) (
   input  logic             fast_clk,
   input  logic             rst,
   input  logic             load,
   input  logic [SYM_W-1:0] hold_word,
   output logic             ser_rise,
   output logic             ser_fall
);

   logic [SYM_W-1:0] sh_q;
   logic [SYM_W-1:0] nxt;

   // On a load the new word's lowest pair goes straight to the outputs
   assign nxt = load ? hold_word : sh_q;

   always_ff @(posedge fast_clk or posedge rst) begin
      if (rst) begin
         sh_q     <= '0;
         ser_rise <= 1'b0;
         ser_fall <= 1'b0;
      end else begin
         sh_q     <= nxt >> LANE_BITS;
         ser_rise <= nxt[0];
         ser_fall <= nxt[1];
      end
   end

endmodule

// File: rtl/tmds_lane_serializer.sv
`timescale 1ns/1ps
module tmds_lane_serializer
   import tmds_ser_pkg::*;
#(
   parameter int unsigned SYM_W = 10,
   parameter lane_kind_e  KIND  = LANE_DATA
) (
   input  logic             pix_clk,
   input  logic             fast_clk,
   input  logic             rst,
   input  logic [SYM_W-1:0] word_in,
   output logic             ser_rise,
   output logic             ser_fall
);

   localparam int unsigned BEATS  = SYM_W / LANE_BITS;
   localparam int unsigned BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
   localparam logic [SYM_W-1:0] CLK_WORD = SYM_W'(clock_word(SYM_W));

   generate
      if ((SYM_W % LANE_BITS) != 0) begin : g_bad_width
         $error("SYM_W must be a multiple of the bits per fast cycle");
      end
      if ((SYM_W < 4) || (SYM_W > MAX_SYM_W)) begin : g_bad_range
         $error("SYM_W out of supported range");
      end
   endgenerate

   logic [SYM_W-1:0]  hold_w;
   logic              tog_w;
   logic              load_w;
   logic [BEAT_W-1:0] beat_w;

   tser_word_hold #(
      .SYM_W      (SYM_W),
      .KIND       (KIND),
      .FIXED_WORD (CLK_WORD)
   ) hold_i (
      .pix_clk   (pix_clk),
      .rst       (rst),
      .word_in   (word_in),
      .hold_word (hold_w),
      .pix_tog   (tog_w)
   );

   tser_beat_sync #(
      .BEATS  (BEATS),
      .BEAT_W (BEAT_W)
   ) sync_i (
      .fast_clk (fast_clk),
      .rst      (rst),
      .pix_tog  (tog_w),
      .load     (load_w),
      .beat     (beat_w)
   );

   tser_shifter #(
      .SYM_W (SYM_W)
   ) shift_i (
      .fast_clk  (fast_clk),
      .rst       (rst),
      .load      (load_w),
      .hold_word (hold_w),
      .ser_rise  (ser_rise),
      .ser_fall  (ser_fall)
   );

endmodule

// File: rtl/tmds_lane_ser_chk.sv
`timescale 1ns/1ps
module tmds_lane_ser_chk
   import tmds_ser_pkg::*;
#(
   parameter int unsigned SYM_W  = 10,
   parameter lane_kind_e  KIND   = LANE_DATA,
   parameter int unsigned BEATS  = 5,
   parameter int unsigned BEAT_W = 3
) (
   input logic              fast_clk,
   input logic              rst,
   input logic              load,
   input logic [BEAT_W-1:0] beat,
   input logic [SYM_W-1:0]  hold_word,
   input logic              ser_rise,
   input logic              ser_fall
);

   // R4: outputs held low during reset
   always @(posedge fast_clk) begin
      if (rst) begin
         p_reset_quiet_r4: assert (!ser_rise && !ser_fall)
            else $error("outputs active during reset");
      end
   end

   // R7: beat index bounded
   p_beat_bound_r7: assert property (@(posedge fast_clk) disable iff (rst)
      beat < BEAT_W'(BEATS));

   // R7: beat advances by one between loads
   p_beat_adv_r7: assert property (@(posedge fast_clk) disable iff (rst)
      !load |=> (beat == BEAT_W'($past(beat) + 1'b1)));

   // R3: a load restarts the beat index
   p_beat_restart_r3: assert property (@(posedge fast_clk) disable iff (rst)
      load |=> (beat == '0));

   // R2: the first pair after a load is the held word's two lowest bits
   p_first_pair_r2: assert property (@(posedge fast_clk) disable iff (rst)
      $past(load) |-> ((ser_rise == $past(hold_word[0])) &&
                       (ser_fall == $past(hold_word[1]))));

   generate
      if (KIND == LANE_CLOCK) begin : g_clk_chk
         // R6: clock symbol begins low on both edges
         p_clock_start_r6: assert property (@(posedge fast_clk) disable iff (rst)
            $past(load) |-> (!ser_rise && !ser_fall));
      end
   endgenerate

endmodule

bind tmds_lane_serializer tmds_lane_ser_chk #(
   .SYM_W  (SYM_W),
   .KIND   (KIND),
   .BEATS  (BEATS),
   .BEAT_W (BEAT_W)
) chk_i (
   .fast_clk  (fast_clk),
   .rst       (rst),
   .load      (load_w),
   .beat      (beat_w),
   .hold_word (hold_w),
   .ser_rise  (ser_rise),
   .ser_fall  (ser_fall)
);

// File: tb/tmds_lane_serializer_tb_top.sv
`timescale 1ns/1ps
module tmds_lane_serializer_tb_top;
   import tmds_ser_pkg::*;

   localparam int unsigned NV = 14;
   localparam logic [9:0] VEC [0:NV-1] = '{
      10'h000, 10'h3FF, 10'h001, 10'h002, 10'h200, 10'h100, 10'h155,
      10'h2AA, 10'h354, 10'h0AB, 10'h31C, 10'h0F0, 10'h3E0, 10'h01F
   };
   localparam logic [9:0] CLK_PAT = 10'b1111100000;

   logic       fast_clk = 1'b0;
   logic       pix_clk  = 1'b0;
   logic       rst      = 1'b1;
   logic [9:0] word_in  = '0;
   logic [9:0] junk_in  = 10'h2D3;
   logic       d_rise, d_fall, c_rise, c_fall;

   int n_cmp = 0;
   int n_bad = 0;

   tmds_lane_serializer #(.SYM_W(10), .KIND(LANE_DATA)) dut_i (
      .pix_clk(pix_clk), .fast_clk(fast_clk), .rst(rst), .word_in(word_in),
      .ser_rise(d_rise), .ser_fall(d_fall));

   tmds_lane_serializer #(.SYM_W(10), .KIND(LANE_CLOCK)) clk_lane_i (
      .pix_clk(pix_clk), .fast_clk(fast_clk), .rst(rst), .word_in(junk_in),
      .ser_rise(c_rise), .ser_fall(c_fall));

   // 50 MHz fast clock, pixel clock at one fifth, rising edges aligned
   initial forever #10 fast_clk = ~fast_clk;
   initial begin
      #10;
      forever begin
         pix_clk = 1'b1; #50;
         pix_clk = 1'b0; #50;
      end
   end

   // Junk on the clock lane input changes every pixel period
   always @(negedge pix_clk) junk_in <= {junk_in[8:0], junk_in[9] ^ junk_in[6]};

   task automatic check(string req, logic [9:0] act, logic [9:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   // Drive n words from the table; rebuild both lanes; check R5 quiet window
   task automatic stream(int start, int n);
      fork
         begin : drv
            for (int i = 0; i < n; i++) begin
               @(negedge pix_clk);
               word_in = VEC[start + i];
            end
         end
         begin : quiet
            for (int k = 0; k < 4; k++) begin
               @(negedge fast_clk);
               check("R5 data lane low before first word", {8'h0, d_fall, d_rise}, 10'h000);
            end
         end
         begin : col
            @(posedge pix_clk);
            #1;
            repeat (2) @(posedge fast_clk);
            for (int w = 0; w < n; w++) begin
               logic [9:0] dw, cw;
               dw = '0;
               cw = '0;
               for (int b = 0; b < 5; b++) begin
                  @(negedge fast_clk);
                  dw[2*b]     = d_rise;
                  dw[2*b + 1] = d_fall;
                  cw[2*b]     = c_rise;
                  cw[2*b + 1] = c_fall;
               end
               check("R1 R2 R3 data word rebuilt", dw, VEC[start + w]);
               check("R6 clock lane pattern", cw, CLK_PAT);
            end
         end
      join
   endtask

   initial begin
      word_in = 10'h3FF;
      #205;
      check("R4 data rise in reset", {9'h0, d_rise}, 10'h000);
      check("R4 data fall in reset", {9'h0, d_fall}, 10'h000);
      check("R4 clock rise in reset", {9'h0, c_rise}, 10'h000);
      check("R4 clock fall in reset", {9'h0, c_fall}, 10'h000);
      #150;
      rst = 1'b0;
      stream(0, NV);

      // Drive ones so a mid-word reset has something to clear
      word_in = 10'h3FF;
      repeat (12) @(posedge fast_clk);
      @(negedge fast_clk);
      check("R2 all-ones steady", {8'h0, d_fall, d_rise}, 10'h003);
      rst = 1'b1;
      #1;
      check("R4 data rise cleared mid-word", {9'h0, d_rise}, 10'h000);
      check("R4 data fall cleared mid-word", {9'h0, d_fall}, 10'h000);
      check("R4 clock lane cleared mid-word", {8'h0, c_fall, c_rise}, 10'h000);
      repeat (3) @(posedge pix_clk);
      #45;
      rst = 1'b0;
      stream(4, 6);

      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge fast_clk);
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      summary();
      $finish;
   end

endmodule